// File: doc/BRIEF.md
# Dual-Ratio Performance Mode Sequencer

This block moves a processor core between two operating points: a low core-to-bus ratio for battery operation and a high ratio for full performance. The bus clock keeps its frequency and the core is never reset; instead the block parks the core in its deepest sleep state, changes the core voltage and the active-low ratio-select line in a fixed order, and then wakes the core again.

Software or a power manager pulses `up_req` or `dn_req`. Before any sleep request the block asks for the local timer and performance-counter interrupt sources to be masked and waits for confirmation. Each later step waits for a handshake input: sleep acknowledge, a voltage-high indication, and sleep acknowledge dropping on wake. Every wait is bounded by a programmable cycle limit; when it runs out, a sticky fault is raised and the core is left asleep with its outputs frozen until reset. The `perf_mode` output tells which mode is active, and `cnt_valid` tells whether the time-stamp and performance counters can be trusted.

Top module: `perf_mode_seq`

## Requirements
- R1: After reset `ratio_sel_n`=1, `vhigh_sel`=0, `sleep_req`=0, `irq_mask_req`=0, `perf_mode`=0 (low mode), `fault`=0 and `cnt_valid`=1.
- R2: An up-shift raises `irq_mask_req`, then `sleep_req`, raises `vhigh_sel` only while `sleep_ack`=1, drives `ratio_sel_n` low, and finally drops `sleep_req`; afterwards `perf_mode`=1, `vhigh_sel`=1, `ratio_sel_n`=0.
- R3: A down-shift enters sleep, drives `ratio_sel_n` high while `vhigh_sel` is still 1, then lowers `vhigh_sel`, then drops `sleep_req`; afterwards `perf_mode`=0, `vhigh_sel`=0, `ratio_sel_n`=1.
- R4: `ratio_sel_n` changes only on a clock edge at which `sleep_ack`=1.
- R5: `ratio_sel_n` falls only on an edge where `vhi_ok`=1 and `vhigh_sel`=1; `vhigh_sel` falls only while `ratio_sel_n`=1.
- R6: `sleep_req` rises only on an edge where `irq_masked_ack`=1 with `irq_mask_req`=1, and `irq_mask_req` stays 1 for as long as `sleep_req` is 1.
- R7: `cnt_valid` is 0 in every cycle in which `sleep_req` or `sleep_ack` is 1.
- R8: A request for the mode already active starts no sequence: `sleep_req` and `irq_mask_req` stay 0 and `perf_mode` keeps its value.
- R9: A request arriving while a sequence runs is held and served once the sequence has returned to normal; if it asks for the mode just reached it is dropped.
- R10: If a handshake stays unmet for `timeout_lim`+1 consecutive cycles of one wait step, `fault` goes to 1 and stays 1, and `sleep_req`, `vhigh_sel`, `ratio_sel_n` and `perf_mode` hold their values until reset.
- R11: `perf_mode` changes only on an edge at which `sleep_req`=0 and `sleep_ack`=0, i.e. when the wake handshake completes.
- R12: If `up_req` and `dn_req` are pulsed in the same cycle, the up request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Pulse: request the high-ratio mode |
| dn_req | input | 1 | Pulse: request the low-ratio mode |
| timeout_lim | input | TW | Cycle limit for each handshake wait |
| irq_masked_ack | input | 1 | Timer and counter interrupt sources are masked |
| sleep_ack | input | 1 | Core is in deep sleep |
| vhi_ok | input | 1 | High core voltage present and settled |
| irq_mask_req | output | 1 | Request to mask timer and counter interrupts |
| sleep_req | output | 1 | Request to hold the core in deep sleep |
| vhigh_sel | output | 1 | Core voltage select, 1 = high |
| ratio_sel_n | output | 1 | Active-low ratio select, 0 = high ratio |
| perf_mode | output | 1 | Current mode, 1 = performance |
| cnt_valid | output | 1 | Time-stamp and performance counters trustworthy |
| fault | output | 1 | Sticky handshake timeout flag |

## Verification
The bench drives handshake responders with random delays and tracks every edge of the sequencing outputs, so a design that flips the ratio line before the voltage has settled, lowers the voltage while the high ratio is still selected, or touches the ratio line outside sleep is caught on the edge it happens. Requests issued mid-sequence, requests for the active mode and simultaneous up and down pulses probe the pending logic; a design that drops or double-serves a request ends in the wrong mode or with an extra sleep entry. A stalled voltage responder with a short limit checks that a timeout freezes the core asleep rather than waking it with a voltage and ratio that do not match.

// File: rtl/perf_mode_seq_pkg.sv
package perf_mode_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_MASK  = 4'd1,
        S_ENTER = 4'd2,
        S_VUP   = 4'd3,
        S_RLO   = 4'd4,
        S_RHI   = 4'd5,
        S_VDN   = 4'd6,
        S_EXIT  = 4'd7,
        S_FAULT = 4'd8
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       tgt;
        logic       mode;
        logic       mask;
        logic       slp;
        logic       vhi;
        logic       rsel_n;
        logic       flt;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        st:     S_IDLE,
        tgt:    1'b0,
        mode:   1'b0,
        mask:   1'b0,
        slp:    1'b0,
        vhi:    1'b0,
        rsel_n: 1'b1,
        flt:    1'b0
    };

endpackage

// File: rtl/pms_req_hold.sv
module pms_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic dn_req,
    input  logic take,
    output logic pend_up,
    output logic pend_dn
);

    typedef struct packed {
        logic up;
        logic dn;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (take) begin
            pend_d.up = 1'b0;
            pend_d.dn = 1'b0;
        end
        if (up_req) begin
            pend_d.up = 1'b1;
            pend_d.dn = 1'b0;
        end else if (dn_req) begin
            pend_d.up = 1'b0;
            pend_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_up = pend_q.up;
    assign pend_dn = pend_q.dn;

    a_r12_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_up && pend_dn));

    a_r12_up_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && dn_req) |=> pend_up);

endmodule

// File: rtl/pms_wait_timer.sv
module pms_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] lim,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)          cnt_d = '0;
        else if (cnt_q < lim) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= lim);

    a_r10_fresh_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && lim != '0) |=> !expired);

endmodule

// File: rtl/perf_mode_seq.sv
module perf_mode_seq
    import perf_mode_seq_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_req,
    input  logic          dn_req,
    input  logic [TW-1:0] timeout_lim,
    input  logic          irq_masked_ack,
    input  logic          sleep_ack,
    input  logic          vhi_ok,
    output logic          irq_mask_req,
    output logic          sleep_req,
    output logic          vhigh_sel,
    output logic          ratio_sel_n,
    output logic          perf_mode,
    output logic          cnt_valid,
    output logic          fault
);

    seq_regs_t q, n;
    logic      take;
    logic      restart;
    logic      expired;
    logic      pend_up, pend_dn;

    pms_req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_req  (up_req),
        .dn_req  (dn_req),
        .take    (take),
        .pend_up (pend_up),
        .pend_dn (pend_dn)
    );

    pms_wait_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .lim     (timeout_lim),
        .expired (expired)
    );

    always_comb begin
        n    = q;
        take = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (pend_up || pend_dn) begin
                    take = 1'b1;
                    if (pend_up != q.mode) begin
                        n.tgt  = pend_up;
                        n.mask = 1'b1;
                        n.st   = S_MASK;
                    end
                end
            end
            S_MASK: begin
                if (irq_masked_ack) begin
                    n.slp = 1'b1;
                    n.st  = S_ENTER;
                end else if (expired) begin
                    n.flt = 1'b1;
                    n.st  = S_FAULT;
                end
            end
            S_ENTER: begin
                if (sleep_ack) begin
                    if (q.tgt) begin
                        n.vhi = 1'b1;
                        n.st  = S_VUP;
                    end else begin
                        n.rsel_n = 1'b1;
                        n.st     = S_RHI;
                    end
                end else if (expired) begin
                    n.flt = 1'b1;
                    n.st  = S_FAULT;
                end
            end
            S_VUP: begin
                if (vhi_ok && sleep_ack) begin
                    n.rsel_n = 1'b0;
                    n.st     = S_RLO;
                end else if (expired) begin
                    n.flt = 1'b1;
                    n.st  = S_FAULT;
                end
            end
            S_RLO: begin
                n.slp = 1'b0;
                n.st  = S_EXIT;
            end
            S_RHI: begin
                n.vhi = 1'b0;
                n.st  = S_VDN;
            end
            S_VDN: begin
                if (!vhi_ok) begin
                    n.slp = 1'b0;
                    n.st  = S_EXIT;
                end else if (expired) begin
                    n.flt = 1'b1;
                    n.st  = S_FAULT;
                end
            end
            S_EXIT: begin
                if (!sleep_ack) begin
                    n.mode = q.tgt;
                    n.mask = 1'b0;
                    n.st   = S_IDLE;
                end else if (expired) begin
                    n.flt = 1'b1;
                    n.st  = S_FAULT;
                end
            end
            S_FAULT: begin
                n = q;
            end
            default: begin
                n.flt = 1'b1;
                n.st  = S_FAULT;
            end
        endcase
        restart = (n.st != q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= n;
    end

    assign irq_mask_req = q.mask;
    assign sleep_req    = q.slp;
    assign vhigh_sel    = q.vhi;
    assign ratio_sel_n  = q.rsel_n;
    assign perf_mode    = q.mode;
    assign fault        = q.flt;
    assign cnt_valid    = !(q.slp || sleep_ack);

    // R2: voltage goes up only once the core is asleep
    a_r2_vup_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vhigh_sel) |-> (sleep_req && $past(sleep_ack)));

    // R2/R3: the core is released only with a matching voltage and ratio
    a_r2_wake_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_req) |-> (ratio_sel_n == !vhigh_sel));

    a_r3_ratio_up_before_vdown: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_sel_n) |-> vhigh_sel);

    a_r4_ratio_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel_n != $past(ratio_sel_n)) |-> $past(sleep_ack));

    a_r5_ratio_low_after_vgood: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_sel_n) |-> (vhigh_sel && $past(vhi_ok)));

    a_r5_vdown_after_ratio_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vhigh_sel) |-> ratio_sel_n);

    a_r6_sleep_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> ($past(irq_masked_ack) && irq_mask_req));

    a_r6_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> irq_mask_req);

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault) |-> (fault && $stable(sleep_req) && $stable(vhigh_sel)
                          && $stable(ratio_sel_n) && $stable(perf_mode)));

    a_r11_mode_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (perf_mode != $past(perf_mode)) |-> ($past(!sleep_ack) && $past(!sleep_req)));

endmodule

// File: tb/perf_mode_seq_bench.sv
module perf_mode_seq_bench;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0;
    logic          dn_req = 1'b0;
    logic [TW-1:0] timeout_lim = 16'd50;
    logic          irq_masked_ack = 1'b0;
    logic          sleep_ack = 1'b0;
    logic          vhi_ok = 1'b0;
    logic          irq_mask_req, sleep_req, vhigh_sel, ratio_sel_n;
    logic          perf_mode, cnt_valid, fault;

    int checks = 0;
    int errors = 0;
    int entries = 0;
    int cyc = 0;
    bit stall_v = 1'b0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    perf_mode_seq #(.TW(TW)) u_perf_mode_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .up_req         (up_req),
        .dn_req         (dn_req),
        .timeout_lim    (timeout_lim),
        .irq_masked_ack (irq_masked_ack),
        .sleep_ack      (sleep_ack),
        .vhi_ok         (vhi_ok),
        .irq_mask_req   (irq_mask_req),
        .sleep_req      (sleep_req),
        .vhigh_sel      (vhigh_sel),
        .ratio_sel_n    (ratio_sel_n),
        .perf_mode      (perf_mode),
        .cnt_valid      (cnt_valid),
        .fault          (fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Handshake responders, driven on the falling edge
    int d_m = 0, d_s = 0, d_v = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            irq_masked_ack <= 1'b0; sleep_ack <= 1'b0; vhi_ok <= 1'b0;
        end else begin
            if (irq_masked_ack != irq_mask_req) begin
                if (d_m == 0) begin irq_masked_ack <= irq_mask_req; d_m = $urandom % 4; end
                else d_m--;
            end
            if (sleep_ack != sleep_req) begin
                if (d_s == 0) begin sleep_ack <= sleep_req; d_s = $urandom % 4; end
                else d_s--;
            end
            if (!stall_v && vhi_ok != vhigh_sel) begin
                if (d_v == 0) begin vhi_ok <= vhigh_sel; d_v = $urandom % 4; end
                else d_v--;
            end
        end
    end

    // Edge monitor: samples 2 ns after the rising edge; inputs seen are those of that edge
    logic p_ratio = 1'b1, p_vhi = 1'b0, p_slp = 1'b0, p_mode = 1'b0, p_fault = 1'b0;
    always @(posedge clk) begin
        cyc++;
        #2;
        if (mon_on && rst_n) begin
            if (ratio_sel_n != p_ratio) chk(sleep_ack, "R4 ratio change needs sleep_ack", sleep_ack, 1);
            if (p_ratio && !ratio_sel_n) chk(vhigh_sel && vhi_ok, "R5 ratio low before voltage good", vhi_ok, 1);
            if (!p_ratio && ratio_sel_n) chk(vhigh_sel, "R3 ratio high with voltage still high", vhigh_sel, 1);
            if (p_vhi && !vhigh_sel) chk(ratio_sel_n, "R5 voltage down only after ratio high", ratio_sel_n, 1);
            if (!p_vhi && vhigh_sel) chk(sleep_req && sleep_ack, "R2 voltage up only in sleep", sleep_ack, 1);
            if (!p_slp && sleep_req) begin
                entries++;
                chk(irq_mask_req && irq_masked_ack, "R6 sleep before mask ack", irq_masked_ack, 1);
            end
            if (p_slp && !sleep_req) chk(ratio_sel_n == !vhigh_sel, "R2 wake with mismatched ratio", ratio_sel_n, !vhigh_sel);
            if (sleep_req) chk(irq_mask_req, "R6 mask held during sleep", irq_mask_req, 1);
            if (sleep_req || sleep_ack) chk(!cnt_valid, "R7 cnt_valid while asleep", cnt_valid, 0);
            if (perf_mode != p_mode) chk(!sleep_ack && !sleep_req, "R11 mode changed outside wake", sleep_ack, 0);
            if (p_fault) chk(fault && sleep_req == p_slp && ratio_sel_n == p_ratio && vhigh_sel == p_vhi
                             && perf_mode == p_mode, "R10 fault state not frozen", fault, 1);
        end
        p_ratio = ratio_sel_n; p_vhi = vhigh_sel; p_slp = sleep_req;
        p_mode = perf_mode; p_fault = fault;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit exp_entry(input bit mode_now, input bit target);
        return mode_now != target;
    endfunction

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        up_req = up; dn_req = dn;
        @(negedge clk);
        up_req = 1'b0; dn_req = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 400; i++) begin
            if (!irq_mask_req && !sleep_req && !sleep_ack) break;
            @(negedge clk);
        end
    endtask

    task automatic check_mode(input bit m, input string req);
        chk(perf_mode == m, req, perf_mode, m);
        chk(ratio_sel_n == !m, req, ratio_sel_n, !m);
        chk(vhigh_sel == m, req, vhigh_sel, m);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int e0;
        bit m;
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1 reset state
        chk(ratio_sel_n == 1'b1, "R1 ratio_sel_n", ratio_sel_n, 1);
        chk(vhigh_sel == 1'b0, "R1 vhigh_sel", vhigh_sel, 0);
        chk(sleep_req == 1'b0 && irq_mask_req == 1'b0, "R1 sleep/mask", sleep_req, 0);
        chk(perf_mode == 1'b0, "R1 perf_mode", perf_mode, 0);
        chk(fault == 1'b0, "R1 fault", fault, 0);
        chk(cnt_valid == 1'b1, "R1 cnt_valid", cnt_valid, 1);
        mon_on = 1'b1;

        // R8: down request while already low
        e0 = entries;
        pulse(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk(entries == e0 && !irq_mask_req, "R8 redundant down started a sequence", entries - e0, 0);
        check_mode(1'b0, "R8 mode after redundant down");

        // R2 up-shift
        e0 = entries;
        pulse(1'b1, 1'b0);
        wait_idle();
        check_mode(1'b1, "R2 mode after up-shift");
        chk(entries == e0 + 1, "R2 one sleep entry", entries - e0, 1);

        // R8: up request while already high
        e0 = entries;
        pulse(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(entries == e0 && !irq_mask_req, "R8 redundant up started a sequence", entries - e0, 0);
        check_mode(1'b1, "R8 mode after redundant up");

        // R3 down-shift
        e0 = entries;
        pulse(1'b0, 1'b1);
        wait_idle();
        check_mode(1'b0, "R3 mode after down-shift");
        chk(entries == e0 + 1, "R3 one sleep entry", entries - e0, 1);

        // R9: opposite request during a sequence is served afterwards
        e0 = entries;
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 100 && !sleep_req; i++) @(negedge clk);
        pulse(1'b0, 1'b1);
        for (int i = 0; i < 400 && entries < e0 + 2; i++) @(negedge clk);
        wait_idle();
        chk(entries == e0 + 2, "R9 pending request not served", entries - e0, 2);
        check_mode(1'b0, "R9 mode after queued down");

        // R9: same-target request during a sequence is dropped
        e0 = entries;
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 100 && !sleep_req; i++) @(negedge clk);
        pulse(1'b1, 1'b0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(entries == e0 + 1, "R9 same-target request served twice", entries - e0, 1);
        check_mode(1'b1, "R9 mode after duplicate up");

        // R12: both pulses together while high -> up wins -> nothing happens
        e0 = entries;
        pulse(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk(entries == e0, "R12 simultaneous request not up", entries - e0, 0);
        check_mode(1'b1, "R12 mode held");
        pulse(1'b0, 1'b1);
        wait_idle();
        e0 = entries;
        pulse(1'b1, 1'b1);
        wait_idle();
        chk(entries == e0 + 1, "R12 simultaneous request from low", entries - e0, 1);
        check_mode(1'b1, "R12 mode after simultaneous request");

        // Random requests issued while idle
        for (int k = 0; k < 40; k++) begin
            bit t;
            t = 1'($urandom % 2);
            m = perf_mode;
            e0 = entries;
            if (t) pulse(1'b1, 1'b0); else pulse(1'b0, 1'b1);
            wait_idle();
            repeat ($urandom % 4) @(negedge clk);
            chk(entries == e0 + int'(exp_entry(m, t)), "R8 random entry count", entries - e0, int'(exp_entry(m, t)));
            check_mode(t, "R2/R3 random final mode");
        end

        // R10: voltage never settles -> fault, stay asleep
        pulse(1'b0, 1'b1);
        wait_idle();
        timeout_lim = 16'd4;
        stall_v = 1'b1;
        pulse(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        chk(fault == 1'b1, "R10 fault after timeout", fault, 1);
        chk(sleep_req == 1'b1, "R10 core kept asleep", sleep_req, 1);
        chk(ratio_sel_n == 1'b1 && perf_mode == 1'b0, "R10 ratio kept low-mode", ratio_sel_n, 1);
        repeat (20) @(negedge clk);
        chk(fault == 1'b1 && sleep_req == 1'b1, "R10 fault sticky", fault, 1);
        pulse(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk(fault && sleep_req && perf_mode == 1'b0, "R10 requests ignored in fault", sleep_req, 1);

        mon_on = 1'b0;
        stall_v = 1'b0;
        timeout_lim = 16'd50;
        do_reset();
        chk(fault == 1'b0 && sleep_req == 1'b0 && ratio_sel_n == 1'b1, "R1 reset clears fault", fault, 0);
        chk(cnt_valid == 1'b1 && perf_mode == 1'b0, "R1 reset mode", perf_mode, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule